// File: doc/BRIEF.md
# Biphase-Mark Timecode Bit Detector

This block turns a biphase-mark timecode level into a stream of bit decisions. The line arrives from outside the clock domain. It passes through a short synchroniser, and every change of level is then detected, whether the line rises or falls. An edge that marks the start of a cell opens a timing window whose length, in system clock cycles, comes from the `win_len` input. Software sets that length to three quarters of one bit cell for the frame rate in use. A cell is one eightieth of a frame at 24, 25 or 30 frames per second.

If a second edge arrives while the window is open, the cell contained a mid-cell transition and holds a one. If the window closes with no edge, the cell holds a zero. Each decision sets its own sticky interrupt flag. Each flag stays set until its own acknowledge input clears it. After a one, the mid-cell edge is consumed by the decision, and the edge that follows it starts the next cell.

Top module: `bpm_bit_detector`

## Requirements
- R1: After reset, `irq_one` and `irq_zero` are 0. The line is treated as unchanged while the synchroniser fills, so a line held high through reset produces no event.
- R2: A level change on `line_in` takes effect at the third rising clock edge after it is applied. That edge is two synchroniser stages plus one edge-detect stage away.
- R3: Rising and falling transitions are both detected, and either polarity can start a cell.
- R4: The value of `win_len` is captured at the edge that starts a cell. Changes to `win_len` after that edge do not affect the window already open.
- R5: An edge that takes effect 1 to L cycles after the cell-start edge gives a one, where L is the captured `win_len`. An edge that lands on the cycle where the window closes still counts as a one.
- R6: If no edge arrives within L cycles of the cell-start edge, a zero is decided exactly L cycles after that edge.
- R7: The edge that produces a one does not start a new cell. With no later edge, no further decision occurs.
- R8: A one decision sets `irq_one` and a zero decision sets `irq_zero`. Each flag holds until its own acknowledge is high at a clock edge, and an acknowledge has no effect on the other flag.
- R9: If a decision and the matching acknowledge fall on the same clock edge, the flag ends up set.
- R10: A captured `win_len` of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| line_in | input | 1 | Asynchronous biphase-mark timecode level |
| win_len | input | CNT_W | Window length in clock cycles (three quarters of a cell) |
| ack_one | input | 1 | Clears the one interrupt flag |
| ack_zero | input | 1 | Clears the zero interrupt flag |
| irq_one | output | 1 | Sticky flag: a one has been decoded |
| irq_zero | output | 1 | Sticky flag: a zero has been decoded |

## Verification
A wrong internal state shows up at the flag outputs within one cell. A window timer that never closes suppresses zeros. A window that restarts on the mid-cell edge of a one turns the next boundary edge into a spurious one and leaves the following cells out of phase. A bad latency or count shifts when `irq_zero` rises by one or more cycles, and the bench checks that against exact cycle positions. Mixing up the flag paths, or letting a clear win over a set, shows on the very next clock edge after an acknowledge.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_WINDOW = 1'b1
    } bpm_state_e;

    localparam int EV_ONE  = 0;
    localparam int EV_ZERO = 1;
    localparam int N_EV    = 2;

endpackage

// File: rtl/bpm_edge_detect.sv
module bpm_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic edge_o
);
    localparam int FILL_W = $clog2(SYNC_STAGES + 2);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(SYNC_STAGES + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] pipe;
        logic                   last;
        logic [FILL_W-1:0]      fill;
    } sync_t;

    sync_t q, d;

    logic primed;
    assign primed = (q.fill == FILL_MAX);

    always_comb begin
        d      = q;
        d.pipe = {q.pipe[SYNC_STAGES-2:0], line_in};
        d.last = q.pipe[SYNC_STAGES-1];
        if (!primed) begin
            d.fill = q.fill + FILL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // an edge is any level change between the last two settled samples
    assign edge_o = primed && (q.pipe[SYNC_STAGES-1] ^ q.last);

endmodule

// File: rtl/bpm_window_timer.sv
module bpm_window_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [CNT_W-1:0] len,
    output logic             active_o,
    output logic             expire_o
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    // a loaded length of 0 closes the window after one cycle, same as 1
    assign expire_o = q.active && (q.cnt <= CNT_W'(1));
    assign active_o = q.active;

    always_comb begin
        d = q;
        if (start) begin
            d.active = 1'b1;
            d.cnt    = len;
        end else if (q.active) begin
            if (stop || expire_o) begin
                d.active = 1'b0;
            end else begin
                d.cnt = q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/bpm_event_flags.sv
module bpm_event_flags #(
    parameter int N_EV = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EV-1:0] set,
    input  logic [N_EV-1:0] ack,
    output logic [N_EV-1:0] flag
);
    typedef struct packed {
        logic [N_EV-1:0] flag;
    } flg_t;

    flg_t q, d;
    logic [N_EV-1:0] nxt;

    // set has priority over a simultaneous acknowledge
    for (genvar i = 0; i < N_EV; i++) begin : g_flag
        assign nxt[i] = set[i] | (q.flag[i] & ~ack[i]);
    end

    always_comb begin
        d      = q;
        d.flag = nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign flag = q.flag;

endmodule

// File: rtl/bpm_bit_detector.sv
module bpm_bit_detector
    import bpm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic [CNT_W-1:0] win_len,
    input  logic             ack_one,
    input  logic             ack_zero,
    output logic             irq_one,
    output logic             irq_zero
);
    typedef struct packed {
        bpm_state_e state;
    } fsm_t;

    fsm_t q, d;

    logic            edge_pulse;
    logic            tmr_start;
    logic            tmr_active;
    logic            tmr_expire;
    logic            one_evt;
    logic            zero_evt;
    logic [N_EV-1:0] ev_set;
    logic [N_EV-1:0] ev_ack;
    logic [N_EV-1:0] ev_flag;

    bpm_edge_detect #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(line_in),
        .edge_o (edge_pulse)
    );

    // decisions: an edge inside the window wins over a closing window
    assign tmr_start = (q.state == ST_HUNT) && edge_pulse;
    assign one_evt   = (q.state == ST_WINDOW) && edge_pulse;
    assign zero_evt  = (q.state == ST_WINDOW) && !edge_pulse && tmr_expire;

    bpm_window_timer #(
        .CNT_W(CNT_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .stop    (one_evt),
        .len     (win_len),
        .active_o(tmr_active),
        .expire_o(tmr_expire)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_HUNT: begin
                if (edge_pulse) d.state = ST_WINDOW;
            end
            ST_WINDOW: begin
                // the deciding edge is consumed; the next edge opens a cell
                if (one_evt || zero_evt) d.state = ST_HUNT;
            end
            default: d.state = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_HUNT};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        ev_set          = '0;
        ev_ack          = '0;
        ev_set[EV_ONE]  = one_evt;
        ev_set[EV_ZERO] = zero_evt;
        ev_ack[EV_ONE]  = ack_one;
        ev_ack[EV_ZERO] = ack_zero;
    end

    bpm_event_flags #(
        .N_EV(N_EV)
    ) i_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (ev_set),
        .ack  (ev_ack),
        .flag (ev_flag)
    );

    assign irq_one  = ev_flag[EV_ONE];
    assign irq_zero = ev_flag[EV_ZERO];

endmodule

// File: rtl/bpm_bit_detector_chk.sv
module bpm_bit_detector_chk
    import bpm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       edge_seen,
    input bpm_state_e state,
    input logic       tmr_active,
    input logic       one_evt,
    input logic       zero_evt,
    input logic       ack_one,
    input logic       ack_zero,
    input logic       irq_one,
    input logic       irq_zero
);

    assert_one_xor_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(one_evt && zero_evt));

    assert_window_tracks_timer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WINDOW) == tmr_active);

    assert_hunt_no_decision_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT) |-> !(one_evt || zero_evt));

    assert_edge_opens_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && edge_seen) |=> (state == ST_WINDOW));

    assert_one_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        one_evt |=> irq_one);

    assert_zero_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> irq_zero);

    assert_one_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_one && !ack_one) |=> irq_one);

    assert_zero_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_zero && !ack_zero) |=> irq_zero);

    assert_one_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_one && !one_evt) |=> !irq_one);

    assert_zero_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_zero && !zero_evt) |=> !irq_zero);

endmodule

bind bpm_bit_detector bpm_bit_detector_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_seen (edge_pulse),
    .state     (q.state),
    .tmr_active(tmr_active),
    .one_evt   (one_evt),
    .zero_evt  (zero_evt),
    .ack_one   (ack_one),
    .ack_zero  (ack_zero),
    .irq_one   (irq_one),
    .irq_zero  (irq_zero)
);

// File: tb/test_bpm_bit_detector.sv
`timescale 1ns/1ps
module test_bpm_bit_detector;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             line_in = 1'b0;
    logic [CNT_W-1:0] win_len = '0;
    logic             ack_one = 1'b0;
    logic             ack_zero = 1'b0;
    logic             irq_one;
    logic             irq_zero;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    bpm_bit_detector #(.CNT_W(CNT_W)) i_bpm_bit_detector (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .win_len (win_len),
        .ack_one (ack_one),
        .ack_zero(ack_zero),
        .irq_one (irq_one),
        .irq_zero(irq_zero)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic ack_both();
        ack_one  = 1'b1;
        ack_zero = 1'b1;
        tick(1);
        ack_one  = 1'b0;
        ack_zero = 1'b0;
    endtask

    task automatic do_reset(input logic lvl);
        rst_n   = 1'b0;
        line_in = lvl;
        tick(3);
        rst_n = 1'b1;
        tick(5);
    endtask

    // R1: line held high through reset gives no event
    task automatic t_reset();
        do_reset(1'b1);
        chk("R1 irq_one after reset", irq_one, 1'b0);
        chk("R1 irq_zero after reset", irq_zero, 1'b0);
        tick(40);
        chk("R1 irq_one idle high line", irq_one, 1'b0);
        chk("R1 irq_zero idle high line", irq_zero, 1'b0);
    endtask

    // R3 R5 R6 R7: encoded stream, cell 16 cycles, window 12
    task automatic t_stream();
        logic [7:0] bits = 8'b1010_1101;
        win_len = CNT_W'(12);
        for (int i = 0; i < 8; i++) begin
            line_in = ~line_in;
            tick(8);
            if (bits[i]) line_in = ~line_in;
            tick(7);
            chk($sformatf("R5 stream bit %0d irq_one", i), irq_one, bits[i]);
            chk($sformatf("R6 stream bit %0d irq_zero", i), irq_zero, ~bits[i]);
            ack_both();
        end
        tick(40);
        chk("R7 no event after final one", irq_one, 1'b0);
        chk("R7 no zero after final one", irq_zero, 1'b0);
    endtask

    // R2 R5 R6: exact window edge with L = 5
    task automatic t_window_edge();
        win_len = CNT_W'(5);
        line_in = ~line_in;
        tick(5);
        line_in = ~line_in;
        tick(5);
        chk("R5 edge on last window cycle gives one", irq_one, 1'b1);
        chk("R5 edge on last window cycle no zero", irq_zero, 1'b0);
        ack_both();
        tick(20);
        line_in = ~line_in;
        tick(6);
        line_in = ~line_in;
        tick(1);
        chk("R2 zero not before third edge plus L", irq_zero, 1'b0);
        tick(1);
        chk("R6 zero exactly L after cell edge", irq_zero, 1'b1);
        chk("R6 late edge is not a one", irq_one, 1'b0);
        ack_zero = 1'b1;
        tick(1);
        ack_zero = 1'b0;
        tick(4);
        chk("R6 late edge window still open", irq_zero, 1'b0);
        tick(1);
        chk("R6 late edge started new cell, zero", irq_zero, 1'b1);
        ack_both();
        tick(20);
    endtask

    // R4: length captured at cell edge
    task automatic t_len_capture();
        win_len = CNT_W'(20);
        line_in = ~line_in;
        tick(4);
        win_len = CNT_W'(4);
        tick(6);
        line_in = ~line_in;
        tick(5);
        chk("R4 captured length keeps one", irq_one, 1'b1);
        chk("R4 captured length no zero", irq_zero, 1'b0);
        ack_both();
        tick(30);
    endtask

    // R10 R2: length 0 acts as 1
    task automatic t_zero_len();
        win_len = '0;
        line_in = ~line_in;
        tick(3);
        chk("R10 zero length not yet decided", irq_zero, 1'b0);
        tick(1);
        chk("R10 zero length decides after one cycle", irq_zero, 1'b1);
        ack_both();
        tick(10);
    endtask

    // R8 R9: independent sticky flags, set beats ack
    task automatic t_flags();
        win_len = CNT_W'(12);
        line_in = ~line_in;
        tick(16);
        line_in = ~line_in;
        tick(8);
        line_in = ~line_in;
        tick(7);
        chk("R8 zero held without ack", irq_zero, 1'b1);
        chk("R8 one set", irq_one, 1'b1);
        ack_one = 1'b1;
        tick(1);
        ack_one = 1'b0;
        chk("R8 ack_one clears one", irq_one, 1'b0);
        chk("R8 ack_one leaves zero", irq_zero, 1'b1);
        ack_zero = 1'b1;
        tick(1);
        ack_zero = 1'b0;
        chk("R8 ack_zero clears zero", irq_zero, 1'b0);
        tick(20);
        line_in = ~line_in;
        tick(14);
        ack_zero = 1'b1;
        tick(1);
        ack_zero = 1'b0;
        chk("R9 set wins over ack", irq_zero, 1'b1);
        tick(1);
        chk("R9 flag held after ack window", irq_zero, 1'b1);
        ack_both();
    endtask

    initial begin
        t_reset();
        do_reset(1'b0);
        t_stream();
        t_window_edge();
        t_len_capture();
        t_zero_len();
        t_flags();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule